// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Threshold Unit

This block sits next to a FIFO's storage and pointer logic. It keeps two threshold offsets, one for the almost-empty flag and one for the almost-full flag, and drives both flags by comparing each offset with a fill-level view supplied by the pointer logic. The almost-empty flag lives in the read clock domain and compares the read-side fill level. The almost-full flag lives in the write clock domain and compares the free space, which is the depth minus the write-side fill level.

The offsets are programmed over the FIFO's ordinary data ports. While `ofs_load` is high, a write strobe stores the low bits of the write data into the offset currently selected by a small sequencer, and the sequencer then moves on. A read strobe returns the selected offset on the read data bus in the same way. The sequence always starts at the almost-empty offset, then goes to the almost-full offset, then wraps. Dropping `ofs_load` rewinds both sequencers. Reset restores default offsets of 7 words. A mode input chooses between flags taken straight from the comparators and flags that pass through a parameterised number of register stages in their own clock.

`ofs_load` is assumed to be stable or synchronous with respect to both clocks. Offsets are assumed not to change while the read side is reading them back or depending on them for a decision.

Top module: `almflag_offset_loader`

## Requirements
- R1: While either reset is low, the reset clears the state of its own domain. The write-domain reset sets both offsets to 7 and the write sequencer to the almost-empty slot. The read-domain reset sets the read sequencer to the almost-empty slot and `rd_data` to 0. The flag register stages reset to `pae`=1 and `paf`=0.
- R2: On a write clock edge with `ofs_load`=1 and `wr_en`=1, bits [OFS_W-1:0] of `wr_data` (OFS_W=8 by default) go into the selected offset, and the write sequencer advances. The order is almost-empty (slot 0), then almost-full (slot 1), then back to slot 0.
- R3: A write clock edge with `ofs_load`=0 leaves both offsets unchanged, whatever `wr_en` and `wr_data` are.
- R4: On a read clock edge with `ofs_load`=1 and `rd_en`=1, `rd_data` takes the selected offset, zero-extended to DATA_W bits, and the read sequencer advances in the same slot 0 / slot 1 order.
- R5: On any other read clock edge, `rd_data` holds its value.
- R6: A clock edge with `ofs_load`=0 returns that domain's sequencer to slot 0, so the next load sequence begins with the almost-empty offset.
- R7: The almost-empty comparison is true when `rd_fill` <= almost-empty offset.
- R8: The almost-full comparison is true when (DEPTH - `wr_fill`) <= almost-full offset, with DEPTH=256 by default.
- R9: With `async_flags`=0, each flag equals its comparison as sampled SYNC_STAGES (default 2) edges earlier in its own clock. The comparison uses the offset value held before that edge.
- R10: With `async_flags`=1, each flag follows its comparison combinationally, using the current fill level and the current offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write side |
| wr_en | input | 1 | Write strobe; programs an offset while loading |
| wr_data | input | DATA_W | Write data bus; the low OFS_W bits carry the offset |
| wr_fill | input | LVL_W | Fill level as seen by the write side |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read side |
| rd_en | input | 1 | Read strobe; returns an offset while loading |
| rd_data | output | DATA_W | Offset readback, zero-extended |
| rd_fill | input | LVL_W | Fill level as seen by the read side |
| ofs_load | input | 1 | Offset programming mode |
| async_flags | input | 1 | 1: combinational flags, 0: registered flags |
| pae | output | 1 | Almost-empty flag, read domain |
| paf | output | 1 | Almost-full flag, write domain |

## Verification
The bench targets the slot order:
- A third write must wrap back to the almost-empty offset. A sequencer that saturates would keep overwriting the almost-full offset instead.
- Dropping the load for one cycle in the middle of a sequence must restart at slot 0. A missed rewind sends the next value to the wrong offset.

It also targets fill levels exactly at, one below and one above each offset in both modes. An off-by-one comparison, or a free-space calculation taken from the wrong side, flips a flag at exactly one of those points. A wrong number of register stages moves the flag edge by a cycle, and that shows up as a mismatch on the first cycle of every transition. Write strobes without the load and data with high bits set catch offsets that are corrupted or not masked.

// File: rtl/almflag_pkg.sv
// Shared types for the almost-flag threshold unit.
// Assumes exactly two programmable offsets, selected in a fixed order.
package almflag_pkg;

    typedef enum logic {
        SLOT_AE = 1'b0,
        SLOT_AF = 1'b1
    } ofs_slot_e;

    // Next slot in the load order: almost-empty, almost-full, wrap.
    function automatic ofs_slot_e slot_after(ofs_slot_e cur);
        return (cur == SLOT_AE) ? SLOT_AF : SLOT_AE;
    endfunction

endpackage

// File: rtl/almflag_slot_seq.sv
// Slot sequencer for one clock domain.
// Advances on each qualified strobe while loading, and rewinds to the
// almost-empty slot whenever loading is off.
// Assumes load is stable or synchronous to clk.
module almflag_slot_seq
    import almflag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      step,
    output ofs_slot_e slot
);

    ofs_slot_e slot_q;

    // Select the next slot, or rewind when loading stops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_AE;
        end else if (!load) begin
            slot_q <= SLOT_AE;
        end else if (step) begin
            slot_q <= slot_after(slot_q);
        end
    end

    assign slot = slot_q;

    // R2/R4: a qualified strobe during load always moves to the other slot
    a_r2_slot_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (load && step) |=> (slot_q != $past(slot_q)));

    // R6: a cycle without load leaves the sequencer at slot 0
    a_r6_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> (slot_q == SLOT_AE));

endmodule

// File: rtl/almflag_ofs_bank.sv
// Offset register bank, write clock domain.
// Holds one register per slot and stores the low OFS_W bits of the
// write data into the selected slot on each strobe.
// Assumes the strobe is already qualified with the load mode.
module almflag_ofs_bank
    import almflag_pkg::*;
#(
    parameter int OFS_W   = 8,
    parameter int DEF_OFS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  ofs_slot_e        slot,
    input  logic [OFS_W-1:0] din,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);

    localparam int NSLOT = 2;
    localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEF_OFS);

    logic [OFS_W-1:0] ofs_q [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // Store the write data when this slot is selected and strobed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ofs_q[s] <= DEF_V;
            end else if (stb && (int'(slot) == s)) begin
                ofs_q[s] <= din;
            end
        end
    end

    assign ae_ofs = ofs_q[SLOT_AE];
    assign af_ofs = ofs_q[SLOT_AF];

    // R1: reset restores the default offsets
    a_r1_defaults: assert property (@(posedge clk)
        (!rst_n) |=> (ae_ofs == DEF_V && af_ofs == DEF_V));

    // R2: a strobe lands in the slot that was selected
    a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (($past(slot) == SLOT_AE) ? (ae_ofs == $past(din))
                                          : (af_ofs == $past(din))));

    // R3: no strobe, no change
    a_r3_no_touch: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb) |=> ($stable(ae_ofs) && $stable(af_ofs)));

endmodule

// File: rtl/almflag_readback.sv
// Offset readback register, read clock domain.
// Loads the selected offset, zero-extended, on each qualified read
// strobe and holds otherwise.
// Assumes offsets are quasi-static with respect to rd clk while read.
module almflag_readback
    import almflag_pkg::*;
#(
    parameter int OFS_W  = 8,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  ofs_slot_e         slot,
    input  logic [OFS_W-1:0]  ae_ofs,
    input  logic [OFS_W-1:0]  af_ofs,
    output logic [DATA_W-1:0] dout
);

    logic [OFS_W-1:0] pick;

    // Choose the offset addressed by the read sequencer.
    always_comb begin
        pick = (slot == SLOT_AE) ? ae_ofs : af_ofs;
    end

    // Capture the chosen offset on a readback strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (stb) begin
            dout <= DATA_W'(pick);
        end
    end

    // R4: readback returns the offset of the slot that was selected
    a_r4_readback: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (dout == (($past(slot) == SLOT_AE) ? DATA_W'($past(ae_ofs))
                                                   : DATA_W'($past(af_ofs)))));

    // R5: without a strobe the bus holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb) |=> $stable(dout));

endmodule

// File: rtl/almflag_cmp.sv
// Threshold comparator with optional register stages.
// The raw result is lvl <= thr. In registered mode the flag is that
// result delayed by STAGES edges; otherwise it is the raw result.
// Assumes STAGES is 1 or more and small.
module almflag_cmp #(
    parameter int   LVL_W   = 9,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             async_sel,
    input  logic [LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0] thr,
    output logic             flag
);

    localparam int CW = $clog2(STAGES + 1) + 1;

    logic              raw;
    logic [STAGES-1:0] stg_q;
    logic [CW-1:0]     warm_q;

    // Compare the level against the threshold.
    always_comb begin
        raw = (lvl <= thr);
    end

    // Shift the comparison through the register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                stg_q[i] <= stg_q[i-1];
            end
            stg_q[0] <= raw;
        end
    end

    assign flag = async_sel ? raw : stg_q[STAGES-1];

    // Count edges since reset so the lag check only runs on valid history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q < CW'(STAGES)) begin
            warm_q <= warm_q + 1'b1;
        end
    end

    // R9: registered mode lags the comparison by STAGES edges
    a_r9_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm_q >= CW'(STAGES)) && !async_sel) |-> (flag == $past(raw, STAGES)));

    // R1: reset places the register stages at their reset value
    a_r1_flag_reset: assert property (@(posedge clk)
        (!rst_n) |=> (stg_q[STAGES-1] == RST_VAL));

endmodule

// File: rtl/almflag_offset_loader.sv
// Top of the almost-flag threshold unit.
// Writes and reads back the two offsets over the FIFO data ports while
// loading, and drives the almost-empty flag (read domain) and the
// almost-full flag (write domain).
// Assumes wr_fill never exceeds DEPTH, and that ofs_load is stable or
// synchronous to both clocks.
module almflag_offset_loader
    import almflag_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int DATA_W      = 18,
    parameter int SYNC_STAGES = 2,
    parameter int DEF_OFS     = 7,
    localparam int OFS_W      = $clog2(DEPTH),
    localparam int LVL_W      = $clog2(DEPTH + 1)
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LVL_W-1:0]  wr_fill,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [LVL_W-1:0]  rd_fill,
    input  logic              ofs_load,
    input  logic              async_flags,
    output logic              pae,
    output logic              paf
);

    ofs_slot_e        wr_slot;
    ofs_slot_e        rd_slot;
    logic [OFS_W-1:0] ae_ofs;
    logic [OFS_W-1:0] af_ofs;
    logic [LVL_W-1:0] free_lvl;
    logic             wr_stb;
    logic             rd_stb;

    // Qualify both strobes with the load mode.
    always_comb begin
        wr_stb   = ofs_load && wr_en;
        rd_stb   = ofs_load && rd_en;
        free_lvl = LVL_W'(DEPTH) - wr_fill;
    end

    almflag_slot_seq i_wr_seq (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .load  (ofs_load),
        .step  (wr_en),
        .slot  (wr_slot)
    );

    almflag_slot_seq i_rd_seq (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .load  (ofs_load),
        .step  (rd_en),
        .slot  (rd_slot)
    );

    almflag_ofs_bank #(
        .OFS_W   (OFS_W),
        .DEF_OFS (DEF_OFS)
    ) i_bank (
        .clk    (wr_clk),
        .rst_n  (wr_rst_n),
        .stb    (wr_stb),
        .slot   (wr_slot),
        .din    (wr_data[OFS_W-1:0]),
        .ae_ofs (ae_ofs),
        .af_ofs (af_ofs)
    );

    almflag_readback #(
        .OFS_W  (OFS_W),
        .DATA_W (DATA_W)
    ) i_rdbk (
        .clk    (rd_clk),
        .rst_n  (rd_rst_n),
        .stb    (rd_stb),
        .slot   (rd_slot),
        .ae_ofs (ae_ofs),
        .af_ofs (af_ofs),
        .dout   (rd_data)
    );

    almflag_cmp #(
        .LVL_W   (LVL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) i_ae_cmp (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .async_sel (async_flags),
        .lvl       (rd_fill),
        .thr       (LVL_W'(ae_ofs)),
        .flag      (pae)
    );

    almflag_cmp #(
        .LVL_W   (LVL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) i_af_cmp (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .async_sel (async_flags),
        .lvl       (free_lvl),
        .thr       (LVL_W'(af_ofs)),
        .flag      (paf)
    );

    // R7/R10: combinational almost-empty tracks the read fill level
    a_r10_pae_async: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        async_flags |-> (pae == (rd_fill <= LVL_W'(ae_ofs))));

    // R8/R10: combinational almost-full tracks the free space
    a_r10_paf_async: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        async_flags |-> (paf == ((LVL_W'(DEPTH) - wr_fill) <= LVL_W'(af_ofs))));

endmodule

// File: tb/test_almflag_offset_loader.sv
`timescale 1ns/1ps
module test_almflag_offset_loader;

    localparam int DEPTH  = 256;
    localparam int DATA_W = 18;
    localparam int STAGES = 2;
    localparam int LVL_W  = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic ofs_load = 1'b0;
    logic async_flags = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [LVL_W-1:0]  wr_fill = '0;
    logic [LVL_W-1:0]  rd_fill = '0;
    wire  [DATA_W-1:0] rd_data;
    wire               pae;
    wire               paf;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    almflag_offset_loader i_almflag_offset_loader (
        .wr_clk      (clk),
        .wr_rst_n    (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .wr_fill     (wr_fill),
        .rd_clk      (clk),
        .rd_rst_n    (rst_n),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .rd_fill     (rd_fill),
        .ofs_load    (ofs_load),
        .async_flags (async_flags),
        .pae         (pae),
        .paf         (paf)
    );

    // Reference model of the requirements, advanced on every edge.
    int m_ofs [2];
    int m_wsel = 0;
    int m_rsel = 0;
    int m_rd = 0;
    bit pae_q [$];
    bit paf_q [$];
    bit m_live = 1'b0;

    always @(posedge clk) begin
        int old0;
        int old1;
        bit rpae;
        bit rpaf;
        m_live = 1'b1;
        if (!rst_n) begin
            m_ofs[0] = 7;
            m_ofs[1] = 7;
            m_wsel = 0;
            m_rsel = 0;
            m_rd = 0;
            pae_q = {};
            paf_q = {};
            for (int i = 0; i < STAGES; i++) begin
                pae_q.push_back(1'b1);
                paf_q.push_back(1'b0);
            end
        end else begin
            old0 = m_ofs[0];
            old1 = m_ofs[1];
            rpae = (int'(rd_fill) <= old0);
            rpaf = ((DEPTH - int'(wr_fill)) <= old1);
            if (ofs_load && wr_en) begin
                m_ofs[m_wsel] = int'(wr_data) % DEPTH;
                m_wsel = 1 - m_wsel;
            end else if (!ofs_load) begin
                m_wsel = 0;
            end
            if (ofs_load && rd_en) begin
                m_rd = (m_rsel == 0) ? old0 : old1;
                m_rsel = 1 - m_rsel;
            end else if (!ofs_load) begin
                m_rsel = 0;
            end
            pae_q.push_back(rpae);
            void'(pae_q.pop_front());
            paf_q.push_back(rpaf);
            void'(paf_q.pop_front());
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output at each falling edge.
    always @(negedge clk) begin
        int e_pae;
        int e_paf;
        if (m_live) begin
            if (async_flags) begin
                e_pae = (int'(rd_fill) <= m_ofs[0]) ? 1 : 0;
                e_paf = ((DEPTH - int'(wr_fill)) <= m_ofs[1]) ? 1 : 0;
            end else begin
                e_pae = pae_q[0] ? 1 : 0;
                e_paf = paf_q[0] ? 1 : 0;
            end
            chk("R4/R5 rd_data", int'(rd_data), m_rd);
            chk(async_flags ? "R7 R10 pae" : "R7 R9 pae", int'(pae), e_pae);
            chk(async_flags ? "R8 R10 paf" : "R8 R9 paf", int'(paf), e_paf);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input int v);
        ofs_load = 1'b1;
        wr_en = 1'b1;
        wr_data = DATA_W'(v);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic get(input string tag, input int exp);
        ofs_load = 1'b1;
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        chk(tag, int'(rd_data), exp);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 pae", int'(pae), 1);
        chk("R1 paf", int'(paf), 0);
        rst_n = 1'b1;
        tick();
        // R1/R4: defaults read back in slot order
        get("R1 R4 ae default", 7);
        get("R1 R4 af default", 7);
        ofs_load = 1'b0;
        tick();
        // R2: masked writes, slot order, then wrap
        put(18'h3_0014);
        put(18'h2_001E);
        get("R2 R4 ae", 20);
        get("R2 R4 af", 30);
        put(5);
        get("R2 wrap to ae", 5);
        ofs_load = 1'b0;
        tick();
        // R6: dropping load mid-sequence rewinds
        put(40);
        ofs_load = 1'b0;
        tick();
        put(50);
        ofs_load = 1'b0;
        tick();
        get("R6 ae after rewind", 50);
        get("R6 af untouched", 30);
        ofs_load = 1'b0;
        tick();
        // R3/R5: strobes without load
        for (int i = 0; i < 4; i++) begin
            wr_en = 1'b1;
            rd_en = 1'b1;
            wr_data = DATA_W'(99 + i);
            tick();
        end
        wr_en = 1'b0;
        rd_en = 1'b0;
        chk("R5 hold", int'(rd_data), 30);
        get("R3 ae kept", 50);
        get("R3 af kept", 30);
        ofs_load = 1'b0;
        // R7/R8/R9/R10: levels around both thresholds in both modes
        for (int m = 0; m < 2; m++) begin
            async_flags = m[0];
            for (int d = -1; d <= 1; d++) begin
                rd_fill = LVL_W'(50 + d);
                wr_fill = LVL_W'(DEPTH - 30 + d);
                repeat (3) tick();
                chk("R7 pae level", int'(pae), (50 + d <= 50) ? 1 : 0);
                chk("R8 paf level", int'(paf), (30 - d <= 30) ? 1 : 0);
            end
        end
        // Mixed traffic, compared every cycle by the model
        for (int i = 0; i < 3000; i++) begin
            ofs_load = ($urandom % 4) == 0;
            wr_en = $urandom % 2;
            rd_en = $urandom % 2;
            wr_data = DATA_W'($urandom);
            if ($urandom % 50 == 0) async_flags = ~async_flags;
            rd_fill = LVL_W'($urandom % (DEPTH + 1));
            wr_fill = LVL_W'($urandom % (DEPTH + 1));
            tick();
        end
        ofs_load = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        tick();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule